// File: doc/BRIEF.md
# Floating-Point NaN Classifier and Quieter

This unit examines one floating-point operand in either the 32-bit or the 64-bit binary layout. It reports whether the operand is a quiet NaN, a signaling NaN, or neither. It also gives two words: a quieted version of the operand and the default NaN pattern for the selected layout. The result is registered, so outputs appear one clock after the operand is presented. A floating-point datapath uses the unit ahead of its NaN propagation logic.

The unit supports two conventions for the top fraction bit, chosen by one mode input at run time. In the revised convention, a clear top fraction bit marks a signaling NaN; quieting sets that bit and keeps the sign and the payload. In the legacy convention, a set top fraction bit marks a signaling NaN; quieting replaces the whole operand with the default NaN, because setting one bit cannot be relied on to give a quiet NaN in that convention.

Top module: `fpnan_unit`

## Requirements
- R1: An operand is a NaN exactly when its exponent field is all ones and its fraction is nonzero. An all-ones exponent with a zero fraction (infinity) reports neither quiet nor signaling, and `is_quiet` and `is_signaling` are never both 1.
- R2: With `legacy_pol`=0 (revised convention), a NaN whose top fraction bit (bit 22 for 32-bit, bit 51 for 64-bit) is 1 is quiet, and a NaN whose top fraction bit is 0 is signaling.
- R3: With `legacy_pol`=1 (legacy convention), a NaN whose top fraction bit is 1 is signaling, and a NaN whose top fraction bit is 0 is quiet.
- R4: `default_nan` has sign 0 and an all-ones exponent. In the revised convention only the top fraction bit is set (0x7FC00000 / 0x7FF8000000000000). In the legacy convention every fraction bit except the top one is set (0x7FBFFFFF / 0x7FF7FFFFFFFFFFFF).
- R5: In the revised convention, `quiet_word` for a signaling NaN is the operand with its top fraction bit set, with the sign and the other fraction bits unchanged.
- R6: In the legacy convention, `quiet_word` for a signaling NaN equals `default_nan`.
- R7: For an operand that is not a signaling NaN (quiet NaN, infinity or any other value), `quiet_word` equals the operand.
- R8: With `fmt_dbl`=0 (32-bit layout), `op_in[63:32]` has no effect and `quiet_word[63:31+1]` and `default_nan[63:32]` are zero. With `fmt_dbl`=1 the whole 64-bit word is used.
- R9: All outputs are registered. They reflect the inputs sampled at the previous rising clock edge, and they are all zero while `rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt_dbl | input | 1 | 1 = 64-bit layout, 0 = 32-bit layout in bits [31:0] |
| legacy_pol | input | 1 | 1 = set top fraction bit means signaling; 0 = clear top fraction bit means signaling |
| op_in | input | 64 | Operand word |
| is_quiet | output | 1 | Operand is a quiet NaN |
| is_signaling | output | 1 | Operand is a signaling NaN |
| quiet_word | output | 64 | Quieted operand, or the operand unchanged when it is not signaling |
| default_nan | output | 64 | Default NaN for the selected layout and convention |

## Verification
The bench uses infinities of both signs and both widths. A design that tests only the exponent would call these NaNs, and one that tests only the top fraction bit would call them signaling in one of the conventions. It applies the same bit patterns under both conventions, which catches a swapped polarity, and it checks legacy quieting, where a design that only flips one bit would return a value that is still signaling. It also puts a 32-bit signaling pattern with junk above it in 32-bit mode, and the same pattern in the low half of a 64-bit word, to catch upper bits leaking through or a wrong field split.

// File: rtl/fpnan_pkg.sv
package fpnan_pkg;
    localparam int WORD_W  = 64;
    localparam int SP_EXP  = 8;
    localparam int SP_FRAC = 23;
    localparam int DP_EXP  = 11;
    localparam int DP_FRAC = 52;
    localparam int SP_W    = 1 + SP_EXP + SP_FRAC;
    localparam int DP_W    = 1 + DP_EXP + DP_FRAC;

    typedef struct packed {
        logic              quiet;
        logic              sig;
        logic [WORD_W-1:0] word;
        logic [WORD_W-1:0] dflt;
    } nan_res_t;
endpackage

// File: rtl/fpnan_fields.sv
module fpnan_fields #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int MAG_W = EXP_W + FRAC_W
) (
    input  logic [MAG_W-1:0] mag,
    input  logic             legacy_pol,
    output logic             nan_quiet,
    output logic             nan_sig
);
    logic exp_ones;
    logic top_bit;
    logic rest_nz;
    logic any_nan;

    always_comb begin
        exp_ones  = &mag[MAG_W-1:FRAC_W];
        top_bit   = mag[FRAC_W-1];
        rest_nz   = |mag[FRAC_W-2:0];
        any_nan   = exp_ones && (top_bit || rest_nz);
        nan_sig   = any_nan && (top_bit == legacy_pol);
        nan_quiet = any_nan && !nan_sig;
    end
endmodule

// File: rtl/fpnan_default.sv
module fpnan_default #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic         legacy_pol,
    output logic [W-1:0] pattern
);
    always_comb begin
        pattern                 = '0;
        pattern[W-2:FRAC_W]     = '1;
        if (legacy_pol) begin
            pattern[FRAC_W-2:0] = '1;
        end else begin
            pattern[FRAC_W-1]   = 1'b1;
        end
    end
endmodule

// File: rtl/fpnan_unit.sv
module fpnan_unit
    import fpnan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fmt_dbl,
    input  logic              legacy_pol,
    input  logic [WORD_W-1:0] op_in,
    output logic              is_quiet,
    output logic              is_signaling,
    output logic [WORD_W-1:0] quiet_word,
    output logic [WORD_W-1:0] default_nan
);
    localparam logic [WORD_W-1:0] SP_QBIT = WORD_W'(1) << (SP_FRAC - 1);
    localparam logic [WORD_W-1:0] DP_QBIT = WORD_W'(1) << (DP_FRAC - 1);

    logic            sp_quiet, sp_sig, dp_quiet, dp_sig;
    logic [SP_W-1:0] sp_dflt;
    logic [DP_W-1:0] dp_dflt;
    nan_res_t        res_d, res_q;

    fpnan_fields #(.EXP_W(SP_EXP), .FRAC_W(SP_FRAC)) u_sp_fields (
        .mag(op_in[SP_W-2:0]), .legacy_pol(legacy_pol),
        .nan_quiet(sp_quiet), .nan_sig(sp_sig));

    fpnan_fields #(.EXP_W(DP_EXP), .FRAC_W(DP_FRAC)) u_dp_fields (
        .mag(op_in[DP_W-2:0]), .legacy_pol(legacy_pol),
        .nan_quiet(dp_quiet), .nan_sig(dp_sig));

    fpnan_default #(.EXP_W(SP_EXP), .FRAC_W(SP_FRAC)) u_sp_dflt (
        .legacy_pol(legacy_pol), .pattern(sp_dflt));

    fpnan_default #(.EXP_W(DP_EXP), .FRAC_W(DP_FRAC)) u_dp_dflt (
        .legacy_pol(legacy_pol), .pattern(dp_dflt));

    always_comb begin
        logic [WORD_W-1:0] opnd;
        logic [WORD_W-1:0] quieted;
        if (fmt_dbl) begin
            opnd        = WORD_W'(op_in[DP_W-1:0]);
            res_d.quiet = dp_quiet;
            res_d.sig   = dp_sig;
            res_d.dflt  = WORD_W'(dp_dflt);
            quieted     = opnd | DP_QBIT;
        end else begin
            opnd        = WORD_W'(op_in[SP_W-1:0]);
            res_d.quiet = sp_quiet;
            res_d.sig   = sp_sig;
            res_d.dflt  = WORD_W'(sp_dflt);
            quieted     = opnd | SP_QBIT;
        end
        if (legacy_pol) begin
            quieted = res_d.dflt;
        end
        res_d.word = res_d.sig ? quieted : opnd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign is_quiet     = res_q.quiet;
    assign is_signaling = res_q.sig;
    assign quiet_word   = res_q.word;
    assign default_nan  = res_q.dflt;
endmodule

// File: rtl/fpnan_unit_chk.sv
module fpnan_unit_chk #(
    parameter int W      = 64,
    parameter int DFRAC  = 52
) (
    input logic         clk,
    input logic         rst_n,
    input logic         fmt_dbl,
    input logic         legacy_pol,
    input logic [W-1:0] op_in,
    input logic         is_quiet,
    input logic         is_signaling,
    input logic [W-1:0] quiet_word,
    input logic [W-1:0] default_nan
);
    // R1
    excl_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_quiet && is_signaling));

    // R8
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fmt_dbl |=> (quiet_word[W-1:32] == '0 && default_nan[W-1:32] == '0));

    // R6
    legacy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_pol |=> (!is_signaling || quiet_word == default_nan));

    // R5
    revised_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!legacy_pol && fmt_dbl) |=>
            (!is_signaling || quiet_word == ($past(op_in) | (W'(1) << (DFRAC - 1)))));

    // R4
    dflt_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_dbl |=> !default_nan[W-1]);
endmodule

bind fpnan_unit fpnan_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .fmt_dbl(fmt_dbl), .legacy_pol(legacy_pol),
    .op_in(op_in), .is_quiet(is_quiet), .is_signaling(is_signaling),
    .quiet_word(quiet_word), .default_nan(default_nan));

// File: tb/fpnan_unit_test.sv
module fpnan_unit_test;
    typedef struct packed {
        logic        fmt;
        logic        leg;
        logic [63:0] op;
        logic        q;
        logic        s;
        logic [63:0] w;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 64'h7FC00001, 1'b1, 1'b0, 64'h7FC00001},
        '{1'b0, 1'b0, 64'h7F800001, 1'b0, 1'b1, 64'h7FC00001},
        '{1'b0, 1'b0, 64'hFFA00000, 1'b0, 1'b1, 64'hFFE00000},
        '{1'b0, 1'b0, 64'h7F800000, 1'b0, 1'b0, 64'h7F800000},
        '{1'b0, 1'b1, 64'h7FC00000, 1'b0, 1'b1, 64'h7FBFFFFF},
        '{1'b0, 1'b1, 64'h7F800001, 1'b1, 1'b0, 64'h7F800001},
        '{1'b0, 1'b1, 64'hFF800000, 1'b0, 1'b0, 64'hFF800000},
        '{1'b0, 1'b0, 64'hDEADBEEF_7F800005, 1'b0, 1'b1, 64'h7FC00005},
        '{1'b1, 1'b0, 64'h7FF0000000000001, 1'b0, 1'b1, 64'h7FF8000000000001},
        '{1'b1, 1'b0, 64'hFFF8000000000000, 1'b1, 1'b0, 64'hFFF8000000000000},
        '{1'b1, 1'b1, 64'h7FF8000000000000, 1'b0, 1'b1, 64'h7FF7FFFFFFFFFFFF},
        '{1'b1, 1'b1, 64'h7FF4000000000000, 1'b1, 1'b0, 64'h7FF4000000000000},
        '{1'b1, 1'b0, 64'h7FF0000000000000, 1'b0, 1'b0, 64'h7FF0000000000000},
        '{1'b1, 1'b0, 64'h000000007F800001, 1'b0, 1'b0, 64'h000000007F800001},
        '{1'b0, 1'b0, 64'h3F800000, 1'b0, 1'b0, 64'h3F800000},
        '{1'b1, 1'b1, 64'hFFF0000000000000, 1'b0, 1'b0, 64'hFFF0000000000000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fmt_dbl = 1'b0;
    logic        legacy_pol = 1'b0;
    logic [63:0] op_in = '0;
    logic        is_quiet, is_signaling;
    logic [63:0] quiet_word, default_nan;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fpnan_unit uut (
        .clk(clk), .rst_n(rst_n), .fmt_dbl(fmt_dbl), .legacy_pol(legacy_pol),
        .op_in(op_in), .is_quiet(is_quiet), .is_signaling(is_signaling),
        .quiet_word(quiet_word), .default_nan(default_nan));

    function automatic logic [63:0] exp_dflt(input logic f, input logic l);
        if (f) return l ? 64'h7FF7FFFFFFFFFFFF : 64'h7FF8000000000000;
        else   return l ? 64'h000000007FBFFFFF : 64'h000000007FC00000;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic apply(input logic f, input logic l, input logic [63:0] o);
        @(negedge clk);
        fmt_dbl = f; legacy_pol = l; op_in = o;
        @(negedge clk);
    endtask

    initial begin
        #100000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 reset quiet", 64'(is_quiet), 64'd0);
        chk("R9 reset sig", 64'(is_signaling), 64'd0);
        chk("R9 reset word", quiet_word, 64'd0);
        chk("R9 reset dflt", default_nan, 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].fmt, VECS[i].leg, VECS[i].op);
            chk($sformatf("R1 R2 R3 quiet v%0d", i), 64'(is_quiet), 64'(VECS[i].q));
            chk($sformatf("R1 R2 R3 sig v%0d", i), 64'(is_signaling), 64'(VECS[i].s));
            chk($sformatf("R5 R6 R7 R8 word v%0d", i), quiet_word, VECS[i].w);
            chk($sformatf("R4 R8 dflt v%0d", i), default_nan, exp_dflt(VECS[i].fmt, VECS[i].leg));
        end

        // R9 latency: output holds until the next rising edge
        apply(1'b0, 1'b0, 64'h7F800001);
        @(negedge clk);
        op_in = 64'h3F800000;
        #1;
        chk("R9 hold sig", 64'(is_signaling), 64'd1);
        @(negedge clk);
        chk("R9 update sig", 64'(is_signaling), 64'd0);

        // R8 upper half changes alone do not alter a 32-bit result
        apply(1'b0, 1'b1, 64'h12345678_7F800003);
        chk("R8 upper ignored word", quiet_word, 64'h7F800003);
        chk("R8 upper ignored quiet", 64'(is_quiet), 64'd1);

        // R9 reset in mid-run clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R9 mid reset word", quiet_word, 64'd0);
        chk("R9 mid reset dflt", default_nan, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule